// File: doc/BRIEF.md
# Backup Mode Entry Controller

This block runs on the slow clock and walks the chip into its backup state, in which the internal core regulator is off. It watches two sources of a shutdown request. One is a software write that carries a regulator-off bit. The other is a processor sleep request with deep sleep selected.

A sleep request is handled by one of two policies, chosen by a sleep-on-exit configuration bit. With the bit clear, the request starts shutdown at once. With the bit set, the request only arms the block, and shutdown starts when the processor leaves its lowest-priority interrupt handler.

Once a request is accepted, it is held for a resynchronisation window of `SYNC_CYCLES` slow cycles. The block then asserts the active-low core reset. One slow cycle later it halts the processor and peripherals, and one slow cycle after that it drops the regulator enable. The block stays in backup until a wake-up input returns it to idle. A separate external-supply mode input keeps the regulator enable low without starting any sequence.

Top module: `bkp_entry_ctrl`

## Requirements
- R1: After reset, and whenever reset is asserted mid-sequence, the outputs are core_rst_n=1, core_halt=0 and reg_en=!ext_supply_sel.
- R2: In idle, a clock edge that samples sw_wr=1 with sw_regoff=1 accepts a request. core_rst_n stays 1 after that edge and the next edge, and becomes 0 after the second edge following it (SYNC_CYCLES=2).
- R3: core_halt rises one edge after core_rst_n falls, and reg_en falls one edge after core_halt rises, so the regulator enable drops 4 edges after the accepting edge.
- R4: With slp_on_exit=0, a sampled slp_req=1 with slp_deep=1 is accepted at once, with the same timing as R2.
- R5: With slp_on_exit=1, a sampled slp_req=1 with slp_deep=1 only arms the block and the outputs stay idle. A later sampled isr_exit=1 is accepted at that edge, with R2 timing.
- R6: The following leave every output unchanged: a sleep request with slp_deep=0, sw_wr with sw_regoff=0, and isr_exit while not armed.
- R7: ext_supply_sel=1 forces reg_en=0 and starts no sequence. core_rst_n and core_halt behave as if ext_supply_sel were 0.
- R8: In backup the outputs hold core_rst_n=0, core_halt=1 and reg_en=0 until wake_req=1 is sampled. The next edge then returns all three outputs to their idle values.
- R9: The block ignores wake_req before backup is reached, and ignores new requests while a sequence or backup is in progress.
- R10: Accepting a request clears any sleep-on-exit arming. A later isr_exit alone then starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | slow clock |
| rst_n | input | 1 | asynchronous active-low reset |
| sw_wr | input | 1 | software control write strobe |
| sw_regoff | input | 1 | regulator-off bit of the write |
| slp_req | input | 1 | processor sleep instruction pulse |
| slp_deep | input | 1 | deep sleep selected with the sleep request |
| slp_on_exit | input | 1 | defer entry until the lowest-priority handler exits |
| isr_exit | input | 1 | pulse when the lowest-priority handler returns |
| ext_supply_sel | input | 1 | external core supply mode, keeps regulator disabled |
| wake_req | input | 1 | wake-up from backup |
| core_rst_n | output | 1 | active-low core reset |
| core_halt | output | 1 | stops processor and peripherals |
| reg_en | output | 1 | core regulator enable |

## Verification
A vector table applies every trigger source next to a near-miss partner. The pairs are a write with and without the regulator-off bit, a sleep request with deep sleep set and clear, and a handler exit with and without prior arming. The pairing shows that qualification depends on the exact bit combination and not just on any strobe. Every accepted vector is traced edge by edge through reset, halt and regulator-off, which pins the resynchronisation length and the one-cycle ordering. Directed cases cover external-supply mode, early wake-ups, requests arriving during backup, stale arming, and a reset in the middle of the sequence.

// File: rtl/bkp_pkg.sv
package bkp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_SYNC = 3'd1,
    ST_RST  = 3'd2,
    ST_STOP = 3'd3,
    ST_OFF  = 3'd4
  } bkp_state_e;

  // core reset is released only before the sync window ends
  function automatic logic f_core_rst_n(bkp_state_e st);
    return (st == ST_IDLE) || (st == ST_SYNC);
  endfunction

  // processor and peripherals are stopped from STOP onwards
  function automatic logic f_core_halt(bkp_state_e st);
    return (st == ST_STOP) || (st == ST_OFF);
  endfunction

  // regulator runs unless in backup or an external supply is selected
  function automatic logic f_reg_en(bkp_state_e st, logic ext_sel);
    return (st != ST_OFF) && !ext_sel;
  endfunction

endpackage

// File: rtl/bkp_trigger.sv
module bkp_trigger (
  input  logic clk,
  input  logic rst_n,
  input  logic idle,
  input  logic sw_wr,
  input  logic sw_regoff,
  input  logic slp_req,
  input  logic slp_deep,
  input  logic slp_on_exit,
  input  logic isr_exit,
  output logic start
);

  logic arm_q;
  logic sw_hit;
  logic now_hit;
  logic arm_set;
  logic exit_hit;

  assign sw_hit   = sw_wr && sw_regoff;
  assign now_hit  = slp_req && slp_deep && !slp_on_exit;
  assign arm_set  = slp_req && slp_deep && slp_on_exit;
  assign exit_hit = arm_q && isr_exit;
  assign start    = idle && (sw_hit || now_hit || exit_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              arm_q <= 1'b0;
    else if (start)          arm_q <= 1'b0;
    else if (idle && arm_set) arm_q <= 1'b1;
  end

  // R6: shallow sleep, regoff-less writes and unarmed exits start nothing
  p_shallow_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!(sw_wr && sw_regoff) && !arm_q && !slp_deep) |-> !start);

  // R10: accepting a request drops any arming
  p_arm_cleared_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !arm_q);

endmodule

// File: rtl/bkp_sync_timer.sv
module bkp_sync_timer #(
  parameter int SYNC_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);

  localparam int CW = (SYNC_CYCLES > 1) ? $clog2(SYNC_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(SYNC_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign done = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (!run)  cnt_q <= '0;
    else if (!done) cnt_q <= cnt_q + 1'b1;
  end

  // R2: every window starts counting from zero
  p_window_fresh_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (cnt_q == '0));

endmodule

// File: rtl/bkp_seq_fsm.sv
module bkp_seq_fsm
  import bkp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       sync_done,
  input  logic       wake,
  output bkp_state_e state
);

  bkp_state_e state_q;
  bkp_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start)     state_d = ST_SYNC;
      ST_SYNC: if (sync_done) state_d = ST_RST;
      ST_RST:                 state_d = ST_STOP;
      ST_STOP:                state_d = ST_OFF;
      ST_OFF:  if (wake)      state_d = ST_IDLE;
      default:                state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state = state_q;

  // R2: reset phase is only reached through the sync window
  p_rst_after_sync_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RST) |-> ($past(state_q) == ST_SYNC));

  // R8: backup persists until wake
  p_off_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OFF && !wake) |=> (state_q == ST_OFF));

  // R9: early wake does not abort the sequence
  p_early_wake_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_SYNC || state_q == ST_RST || state_q == ST_STOP) && wake)
      |=> (state_q != ST_IDLE));

endmodule

// File: rtl/bkp_entry_ctrl.sv
module bkp_entry_ctrl
  import bkp_pkg::*;
#(
  parameter int SYNC_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_wr,
  input  logic sw_regoff,
  input  logic slp_req,
  input  logic slp_deep,
  input  logic slp_on_exit,
  input  logic isr_exit,
  input  logic ext_supply_sel,
  input  logic wake_req,
  output logic core_rst_n,
  output logic core_halt,
  output logic reg_en
);

  bkp_state_e state;
  logic       start;
  logic       sync_run;
  logic       sync_done;
  logic       is_idle;

  assign is_idle  = (state == ST_IDLE);
  assign sync_run = (state == ST_SYNC);

  bkp_trigger u_trigger (
    .clk         (clk),
    .rst_n       (rst_n),
    .idle        (is_idle),
    .sw_wr       (sw_wr),
    .sw_regoff   (sw_regoff),
    .slp_req     (slp_req),
    .slp_deep    (slp_deep),
    .slp_on_exit (slp_on_exit),
    .isr_exit    (isr_exit),
    .start       (start)
  );

  bkp_sync_timer #(.SYNC_CYCLES(SYNC_CYCLES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (sync_run),
    .done  (sync_done)
  );

  bkp_seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .sync_done (sync_done),
    .wake      (wake_req),
    .state     (state)
  );

  assign core_rst_n = f_core_rst_n(state);
  assign core_halt  = f_core_halt(state);
  assign reg_en     = f_reg_en(state, ext_supply_sel);

  // R3: halt only follows an already asserted core reset
  p_halt_after_rst_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_halt) |-> $past(!core_rst_n));

  // R3: regulator drops only after the halt cycle
  p_regoff_after_halt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(reg_en) && !ext_supply_sel && $past(!ext_supply_sel)) |-> $past(core_halt));

  // R8: core reset is released only by a wake-up
  p_release_on_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_rst_n) |-> $past(wake_req));

  // R7: external supply mode alone never asserts core reset
  p_ext_no_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_idle && !start) |=> core_rst_n);

endmodule

// File: tb/bkp_entry_ctrl_bench.sv
`timescale 1ns/1ps
module bkp_entry_ctrl_bench;

  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic sw_wr, sw_regoff, slp_req, slp_deep, slp_on_exit, isr_exit;
  logic ext_supply_sel, wake_req;
  logic core_rst_n, core_halt, reg_en;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  bkp_entry_ctrl #(.SYNC_CYCLES(SYNC)) u_bkp_entry_ctrl (
    .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_regoff(sw_regoff),
    .slp_req(slp_req), .slp_deep(slp_deep), .slp_on_exit(slp_on_exit),
    .isr_exit(isr_exit), .ext_supply_sel(ext_supply_sel), .wake_req(wake_req),
    .core_rst_n(core_rst_n), .core_halt(core_halt), .reg_en(reg_en)
  );

  // {sw_wr, sw_regoff, slp_req, slp_deep, slp_on_exit, isr_exit, pre_arm, enters}
  localparam logic [7:0] VEC [8] = '{
    8'b1100_0001,  // R2 write with regoff
    8'b1000_0000,  // R6 write without regoff
    8'b0011_0001,  // R4 deep sleep now
    8'b0010_0000,  // R6 shallow sleep
    8'b0000_0111,  // R5 armed, handler exit
    8'b0000_0100,  // R6 unarmed exit
    8'b0010_1000,  // R6 shallow sleep-on-exit
    8'b0100_0000   // R6 regoff without strobe
  };

  function automatic string vec_tag(int i);
    case (i)
      0: return "R2";
      2: return "R4";
      4: return "R5";
      default: return "R6";
    endcase
  endfunction

  // expected {core_rst_n, core_halt, reg_en} k edges after the accepting edge
  function automatic logic [2:0] expect_at(int k, bit enter, bit ext);
    if (!enter) return {1'b1, 1'b0, !ext};
    return {k < SYNC, k >= SYNC + 1, !(k >= SYNC + 2) && !ext};
  endfunction

  function automatic logic [2:0] idle_out(bit ext);
    return {1'b1, 1'b0, !ext};
  endfunction

  task automatic chk(string tag, logic [2:0] exp);
    logic [2:0] got;
    got = {core_rst_n, core_halt, reg_en};
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: {rst_n,halt,reg_en} got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_in();
    sw_wr = 0; sw_regoff = 0; slp_req = 0; slp_deep = 0;
    slp_on_exit = 0; isr_exit = 0; wake_req = 0;
  endtask

  task automatic arm_on_exit(string tag, bit ext);
    slp_req = 1; slp_deep = 1; slp_on_exit = 1;
    tick();
    clear_in();
    chk(tag, idle_out(ext));
    tick();
    chk(tag, idle_out(ext));
  endtask

  // inputs already driven; capture edge, then trace 6 edges
  task automatic run_capture(string tag, bit enter, bit ext);
    tick();
    clear_in();
    chk(tag, expect_at(0, enter, ext));
    for (int k = 1; k <= 5; k++) begin
      tick();
      chk(tag, expect_at(k, enter, ext));
    end
  endtask

  task automatic wake(string tag, bit ext);
    wake_req = 1;
    tick();
    wake_req = 0;
    chk(tag, idle_out(ext));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    clear_in();
    ext_supply_sel = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 in reset", idle_out(0));
    rst_n = 1;
    tick();
    chk("R1 after reset", idle_out(0));

    // table walk
    for (int i = 0; i < 8; i++) begin
      logic [7:0] v;
      v = VEC[i];
      if (v[1]) arm_on_exit(vec_tag(i), 0);
      {sw_wr, sw_regoff, slp_req, slp_deep, slp_on_exit, isr_exit} = v[7:2];
      run_capture(vec_tag(i), v[0], 0);
      if (v[0]) wake("R8 wake", 0);
      else begin
        tick();
        chk(vec_tag(i), idle_out(0));
      end
    end

    // R7: external supply mode alone
    ext_supply_sel = 1;
    tick();
    chk("R7 ext idle", idle_out(1));
    for (int k = 0; k < 4; k++) begin
      tick();
      chk("R7 no entry", idle_out(1));
    end
    sw_wr = 1; sw_regoff = 1;
    run_capture("R7 ext entry", 1, 1);
    wake("R7 ext wake", 1);
    ext_supply_sel = 0;
    tick();
    chk("R7 ext off", idle_out(0));

    // R9: wake held through sync/rst/stop is ignored
    sw_wr = 1; sw_regoff = 1;
    tick();
    clear_in();
    chk("R9", expect_at(0, 1, 0));
    wake_req = 1;
    for (int k = 1; k <= SYNC + 1; k++) begin
      tick();
      chk("R9 early wake", expect_at(k, 1, 0));
    end
    wake_req = 0;
    tick();
    chk("R9", expect_at(SYNC + 2, 1, 0));
    tick();
    chk("R8 hold", expect_at(SYNC + 3, 1, 0));
    // R9: new request in backup ignored
    sw_wr = 1; sw_regoff = 1; slp_req = 1; slp_deep = 1;
    tick();
    clear_in();
    chk("R9 req in backup", {1'b0, 1'b1, 1'b0});
    wake("R8 release", 0);
    for (int k = 0; k < 4; k++) begin
      tick();
      chk("R9 stays idle", idle_out(0));
    end

    // R10: arming cleared by an accepted request
    arm_on_exit("R5 arm", 0);
    sw_wr = 1; sw_regoff = 1;
    run_capture("R10 entry", 1, 0);
    wake("R10 wake", 0);
    isr_exit = 1;
    tick();
    isr_exit = 0;
    for (int k = 0; k < 5; k++) begin
      chk("R10 stale exit", idle_out(0));
      tick();
    end

    // R1: reset mid-sequence
    sw_wr = 1; sw_regoff = 1;
    tick();
    clear_in();
    repeat (SYNC + 1) tick();
    chk("R1 pre-reset", expect_at(SYNC + 1, 1, 0));
    rst_n = 0;
    #1;
    chk("R1 mid reset", idle_out(0));
    tick();
    rst_n = 1;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R1 after mid reset", idle_out(0));
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule